// File: doc/BRIEF.md
# Sequential Signed Multiply Unit

This unit is the multi-cycle multiply stage of a small 16-bit accumulator processor. When the decode stage presents the multiply opcode together with an issue strobe, the unit multiplies the two's-complement values in its N and M registers. It builds the 32-bit signed product in place: A holds the running high half and M holds the remaining multiplier bits. There is no separate product register.

Each of the 16 iterations looks at the lowest bit of M. When that bit is set, the unit adds N into A. The sign-extended sum is then shifted right by one across the A:M pair. On the last iteration the multiplier bit is the sign bit, so the unit subtracts N instead of adding it. This gives the correct signed result.

Software must clear A before issuing the multiply. When the work is done, the unit raises a one-cycle done pulse and a one-cycle program-counter increment. A write port loads A, M or N while the unit is idle, which stands in for the other instructions of the processor.

Top module: `seq_mul_unit`

## Requirements
- R1: A multiply starts only when `issue` is high, `opcode` equals F3h (upper nibble Fh, register field 3h) and the unit is idle. Any other opcode, including F2h, F7h, E3h and 73h, leaves `busy` low, leaves A and M unchanged and produces no `pc_inc`.
- R2: `busy` rises on the clock edge that accepts a multiply and stays high for exactly 16 cycles. On the 16th edge after acceptance, `busy` falls and `done` goes high for exactly one cycle.
- R3: If A is zero at the start, then in the `done` cycle A holds bits 31:16 and M holds bits 15:0 of the signed 32-bit product of the starting N and M values.
- R4: N keeps its value throughout and after the multiply.
- R5: `pc_inc` is a one-cycle pulse asserted only in the `done` cycle, so each multiply advances the program counter exactly once.
- R6: An `issue` of F3h while `busy` is high is ignored. Completion stays on the 16th edge after the first acceptance, and no second multiply follows.
- R7: A register write (`wr_en`, with `wr_sel` 0 = A, 1 = M, 2 = N, 3 = none) takes effect on the next edge when the unit is idle. While `busy` is high, writes are ignored.
- R8: The corner products are exact: 8000h×8000h gives A=4000h, M=0000h. 8000h×FFFFh gives A=0000h, M=8000h. 0×x gives zero. FFFFh×FFFFh gives A=0000h, M=0001h.
- R9: While `rst` is high, A, M, N, `busy`, `done` and `pc_inc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Decode strobe for the presented opcode |
| opcode | input | 8 | Instruction opcode |
| wr_en | input | 1 | Register write enable (idle only) |
| wr_sel | input | 2 | Write target: 0 A, 1 M, 2 N, 3 none |
| wr_data | input | 16 | Register write data |
| a_q | output | 16 | A register (product high word) |
| m_q | output | 16 | M register (multiplier, then product low word) |
| n_q | output | 16 | N register (multiplicand) |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_inc | output | 1 | One-cycle program-counter advance |

## Verification
The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the edge that accepts the issue. `busy` must be high after edges 1 through 15. The product, `done` and `pc_inc` are due right after edge 16, and `done` must be low again after edge 17. A register write is due one edge after it is presented. A rejected or ignored issue is judged one edge later from `busy`, A and M. Each check samples at exactly that edge count and never waits for an event.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_M    = 2'd1,
    SEL_N    = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/mul_decode.sv
module mul_decode #(
  parameter int          OPC_W  = 8,
  parameter logic [7:0]  MUL_OP = 8'hF3
) (
  input  logic             issue,
  input  logic [OPC_W-1:0] opcode,
  output logic             hit
);
  always_comb hit = issue && (opcode == OPC_W'(MUL_OP));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic busy,
  output logic step,
  output logic last,
  output logic done,
  output logic pc_inc
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST_IT = CW'(WIDTH - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    step = busy;
    last = busy && (cnt == LAST_IT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      pc_inc <= 1'b0;
    end else begin
      done   <= last;
      pc_inc <= last;
      if (!busy) begin
        if (hit) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
  // R6
  count_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cnt) == LAST_IT));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             step,
  input  logic             last,
  input  logic             wr_en,
  input  wsel_e            wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] a_q,
  output logic [WIDTH-1:0] m_q,
  output logic [WIDTH-1:0] n_q
);
  localparam int EW = WIDTH + 1;

  logic [EW-1:0] ext_a;
  logic [EW-1:0] addend;
  logic [EW-1:0] sum;

  always_comb begin
    ext_a  = {a_q[WIDTH-1], a_q};
    addend = m_q[0] ? {n_q[WIDTH-1], n_q} : '0;
    sum    = last ? (ext_a - addend) : (ext_a + addend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      m_q <= '0;
      n_q <= '0;
    end else if (step) begin
      a_q <= sum[EW-1:1];
      m_q <= {sum[0], m_q[WIDTH-1:1]};
    end else if (wr_en) begin
      case (wr_sel)
        SEL_A:   a_q <= wr_data;
        SEL_M:   m_q <= wr_data;
        SEL_N:   n_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R4
  n_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(n_q));
  // R7
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && wr_sel == SEL_N) |=> (n_q == $past(wr_data)));
endmodule

// File: rtl/seq_mul_unit.sv
module seq_mul_unit
  import mul_pkg::*;
#(
  parameter int         WIDTH  = 16,
  parameter int         OPC_W  = 8,
  parameter logic [7:0] MUL_OP = 8'hF3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [OPC_W-1:0] opcode,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] a_q,
  output logic [WIDTH-1:0] m_q,
  output logic [WIDTH-1:0] n_q,
  output logic             busy,
  output logic             done,
  output logic             pc_inc
);
  logic hit;
  logic step;
  logic last;

  mul_decode #(.OPC_W(OPC_W), .MUL_OP(MUL_OP)) u_dec (
    .issue (issue),
    .opcode(opcode),
    .hit   (hit)
  );

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .busy  (busy),
    .step  (step),
    .last  (last),
    .done  (done),
    .pc_inc(pc_inc)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .step   (step),
    .last   (last),
    .wr_en  (wr_en),
    .wr_sel (wsel_e'(wr_sel)),
    .wr_data(wr_data),
    .a_q    (a_q),
    .m_q    (m_q),
    .n_q    (n_q)
  );

  // R1
  start_decode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(issue && opcode == OPC_W'(MUL_OP)));
  // R5
  pc_once_chk: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> ($past(busy) && done));
endmodule

// File: tb/tb_seq_mul_unit.sv
module tb_seq_mul_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [7:0]  opcode;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [15:0] a_q, m_q, n_q;
  logic        busy, done, pc_inc;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  seq_mul_unit dut (
    .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .a_q(a_q), .m_q(m_q), .n_q(n_q),
    .busy(busy), .done(done), .pc_inc(pc_inc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic load(input logic [15:0] nv, input logic [15:0] mv);
    wr(2'd2, nv);
    wr(2'd1, mv);
    wr(2'd0, 16'h0000);
  endtask

  // Issue F3h, then run 17 edges; check timing (R2, R5), product (R3), N (R4).
  task automatic run_mul(input string req, input logic [15:0] nv, input logic [15:0] mv);
    logic signed [15:0] sn, sm;
    logic signed [31:0] prod;
    logic ok_busy;
    sn = nv; sm = mv;
    prod = sn * sm;
    load(nv, mv);
    issue = 1'b1; opcode = 8'hF3;
    tick();
    issue = 1'b0; opcode = 8'h00;
    ok_busy = busy && !done && !pc_inc;
    for (int k = 1; k < 16; k++) begin
      tick();
      if (!busy || done || pc_inc) ok_busy = 1'b0;
    end
    tick();
    chk({"R2 busy window ", req}, {31'd0, ok_busy}, 32'd1);
    chk({"R2 done at edge 16 ", req}, {30'd0, busy, done}, 32'd1);
    chk({"R5 pc_inc with done ", req}, {31'd0, pc_inc}, 32'd1);
    chk({"R3 product ", req}, {a_q, m_q}, prod);
    chk({"R4 N kept ", req}, {16'd0, n_q}, {16'd0, nv});
    tick();
    chk({"R5 single pulse ", req}, {30'd0, done, pc_inc}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; issue = 1'b0; opcode = 8'h00;
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = 16'h0;
    tick(); tick();
    chk("R9 reset regs", {a_q, m_q}, 32'd0);
    chk("R9 reset N/flags", {13'd0, n_q, busy, done, pc_inc}, 32'd0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_corners();
    run_mul("R8 8000x8000", 16'h8000, 16'h8000);
    run_mul("R8 8000xFFFF", 16'h8000, 16'hFFFF);
    run_mul("R8 FFFFx8000", 16'hFFFF, 16'h8000);
    run_mul("R8 0xABCD", 16'h0000, 16'hABCD);
    run_mul("R8 1234x0", 16'h1234, 16'h0000);
    run_mul("R8 FFFFxFFFF", 16'hFFFF, 16'hFFFF);
    chk("R8 FFFFxFFFF words", {a_q, m_q}, 32'h0000_0001);
  endtask

  task automatic t_random();
    for (int i = 0; i < 12; i++) begin
      run_mul("R3 random", 16'($urandom), 16'($urandom));
    end
    run_mul("R3 7FFFx7FFF", 16'h7FFF, 16'h7FFF);
    run_mul("R3 7FFFx8000", 16'h7FFF, 16'h8000);
  endtask

  task automatic t_bad_opcodes();
    logic [7:0] bad [4] = '{8'hF2, 8'hF7, 8'hE3, 8'h73};
    load(16'h0003, 16'h0005);
    for (int i = 0; i < 4; i++) begin
      issue = 1'b1; opcode = bad[i];
      tick();
      issue = 1'b0;
      tick();
      chk("R1 no start on bad opcode", {29'd0, busy, done, pc_inc}, 32'd0);
      chk("R1 A/M unchanged", {a_q, m_q}, 32'h0000_0005);
    end
  endtask

  task automatic t_issue_busy();
    logic stray;
    load(16'h0007, 16'hFFFD);
    issue = 1'b1; opcode = 8'hF3;
    tick();
    issue = 1'b0;
    for (int k = 1; k < 16; k++) begin
      if (k == 8) issue = 1'b1;
      tick();
      issue = 1'b0;
    end
    tick();
    chk("R6 done stays at edge 16", {30'd0, busy, done}, 32'd1);
    chk("R6 product", {a_q, m_q}, 32'hFFFF_FFEB);
    stray = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (busy || done) stray = 1'b1;
    end
    chk("R6 no second multiply", {31'd0, stray}, 32'd0);
    opcode = 8'h00;
  endtask

  task automatic t_write_busy();
    load(16'h0010, 16'h0020);
    chk("R7 idle write N", {16'd0, n_q}, 32'h0010);
    chk("R7 idle write M", {16'd0, m_q}, 32'h0020);
    issue = 1'b1; opcode = 8'hF3;
    tick();
    issue = 1'b0;
    for (int k = 1; k < 16; k++) begin
      if (k == 4) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h1234; end
      if (k == 6) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h5555; end
      tick();
      wr_en = 1'b0; wr_sel = 2'd3;
    end
    tick();
    chk("R7 write ignored, product", {a_q, m_q}, 32'h0000_0200);
    chk("R7 write ignored, N", {16'd0, n_q}, 32'h0010);
  endtask

  initial begin
    t_reset();
    t_bad_opcodes();
    t_corners();
    t_random();
    t_issue_busy();
    t_write_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule